// File: doc/BRIEF.md
# Cross-Coupled Mailbox Register Bank

This block holds the command and status registers shared by a host driver and an embedded CPU. Each side has its own single-cycle read/write port and its own address space: eight registers on the host side and sixteen on the CPU side. Neither side can address the other side's registers. Some bits are linked across the two spaces. A host write shows up as read-only status or as an interrupt on the CPU side, and the same holds in the other direction.

The host drives three control bits: hold the CPU in reset, halt it, and power it down. A four-state machine turns these bits into the CPU control outputs. It has the states ST_RESET, ST_RUN, ST_HALT and ST_SLEEP, and the host can read the current state back.

In any state, the next state is chosen by priority: reset request first, then power-down, then halt, otherwise run. The named transitions are:
- ST_RESET to ST_RUN, ST_HALT or ST_SLEEP when the reset request drops.
- ST_RUN, ST_HALT or ST_SLEEP to ST_RESET whenever the reset request is 1.
- ST_RUN or ST_HALT to ST_SLEEP on a power-down request.
- ST_RUN to ST_HALT on a halt request.
- ST_HALT back to ST_RUN when the halt request drops.
- ST_SLEEP to ST_HALT or ST_RUN when the power-down request drops.

Each direction has a doorbell interrupt. The sender rings it by writing 1, and the receiver clears it by writing 1 (write-1-to-clear).

Top module: `mbx_bank`

## Requirements
- R1: After reset, host register 0 reads 0x01, both interrupt outputs are 0, `cpu_rst_o` is 1 and host register 5 reads 0 (ST_RESET).
- R2: A host write with bit 0 set to host address 1 sets the host-to-CPU pending bit at that clock edge. `h2c_irq_o` then goes high, and bit 0 of CPU address 1 and of host address 1 reads 1.
- R3: A CPU write with bit 0 set to CPU address 1 clears the host-to-CPU pending bit. A write with bit 0 clear leaves it unchanged.
- R4: A CPU write with bit 0 set to CPU address 2 sets the CPU-to-host pending bit. `c2h_irq_o` goes high and bit 0 of host address 2 reads 1. A host write with bit 0 set to host address 2 clears it.
- R5: If a set and a clear of the same pending bit fall in the same cycle, the bit ends up set.
- R6: Host address 0 bit 0 is the CPU reset request. While it is 1, the machine enters or stays in ST_RESET one clock after the register takes the value, and `cpu_rst_o` is 1. Writing 0 releases the CPU.
- R7: Host address 0 bit 1 is the halt request. Without a reset or power-down request, it leads to ST_HALT and `cpu_halt_o` one clock later. Bit 0 of CPU address 0 shows the halt bit at once, and CPU writes to address 0 are ignored.
- R8: Host address 0 bit 2 is the power-down request. It outranks halt and is outranked by reset. It leads to ST_SLEEP and `cpu_pwrdn_o`, and bit 1 of CPU address 0 shows it.
- R9: Host address 3 is a read/write command byte. CPU address 3 reads the same value, and CPU writes to it are ignored.
- R10: CPU address 4 is a read/write response byte. Host address 4 reads the same value, and host writes to it are ignored.
- R11: Host addresses 6 to 7 and CPU addresses 5 to 15 are scratch bytes private to each side. They reset to 0 and are not visible on the other side.
- R12: Bits 1:0 of host address 5 read the state code: 0 ST_RESET, 1 ST_RUN, 2 ST_HALT, 3 ST_SLEEP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| h_we | input | 1 | Host write strobe |
| h_addr | input | 3 | Host register address |
| h_wdata | input | 8 | Host write data |
| h_rdata | output | 8 | Host read data, combinational from h_addr |
| c_we | input | 1 | CPU write strobe |
| c_addr | input | 4 | CPU register address |
| c_wdata | input | 8 | CPU write data |
| c_rdata | output | 8 | CPU read data, combinational from c_addr |
| h2c_irq_o | output | 1 | Interrupt toward the CPU |
| c2h_irq_o | output | 1 | Interrupt toward the host |
| cpu_rst_o | output | 1 | Holds the CPU in reset |
| cpu_halt_o | output | 1 | Halts the CPU |
| cpu_pwrdn_o | output | 1 | Powers the CPU down |

## Verification
The results fall due at two different times:
- Read data is combinational from the address. Stored bytes, pending bits and cross-side status bits therefore read with their new values straight after the clock edge that takes the write.
- The state code and the three CPU control outputs come from the state register, so they change one edge later.

The bench drives each access on a falling edge and samples on the following falling edge. For control changes it checks once at that point, where the old state must still show, and again one cycle later for the new state.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    typedef enum logic [1:0] {
        ST_RESET = 2'd0,
        ST_RUN   = 2'd1,
        ST_HALT  = 2'd2,
        ST_SLEEP = 2'd3
    } cpu_state_e;

    // host-side map
    localparam int H_CTRL  = 0;
    localparam int H_RING  = 1;
    localparam int H_ACK   = 2;
    localparam int H_CMD   = 3;
    localparam int H_RSP   = 4;
    localparam int H_STATE = 5;
    localparam int H_SCR0  = 6;

    // cpu-side map
    localparam int C_STAT  = 0;
    localparam int C_ACK   = 1;
    localparam int C_RING  = 2;
    localparam int C_CMD   = 3;
    localparam int C_RSP   = 4;
    localparam int C_SCR0  = 5;

    // control bits
    localparam int CTRL_RST  = 0;
    localparam int CTRL_HALT = 1;
    localparam int CTRL_PD   = 2;
    localparam int CTRL_W    = 3;

endpackage

// File: rtl/mbx_irq_link.sv
module mbx_irq_link (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic pend_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            pend_o <= 1'b0;
        else if (set_i)
            pend_o <= 1'b1;
        else if (clr_i)
            pend_o <= 1'b0;
    end

    a_r2_set_takes: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> pend_o);

    a_r3_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !pend_o);

    a_r5_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i && clr_i) |=> pend_o);

    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_i && !clr_i) |=> $stable(pend_o));

endmodule

// File: rtl/mbx_ctrl_fsm.sv
module mbx_ctrl_fsm
    import mbx_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [CTRL_W-1:0]   ctrl_i,
    output cpu_state_e          state_o,
    output logic                cpu_rst_o,
    output logic                cpu_halt_o,
    output logic                cpu_pwrdn_o
);

    cpu_state_e state, next;
    logic rq_rst, rq_halt, rq_pd;

    assign rq_rst  = ctrl_i[CTRL_RST];
    assign rq_halt = ctrl_i[CTRL_HALT];
    assign rq_pd   = ctrl_i[CTRL_PD];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_RESET;
        else
            state <= next;
    end

    always_comb begin
        next = state;
        unique case (state)
            ST_RESET: begin
                if (!rq_rst)
                    next = rq_pd ? ST_SLEEP : (rq_halt ? ST_HALT : ST_RUN);
            end
            ST_RUN: begin
                if (rq_rst)       next = ST_RESET;
                else if (rq_pd)   next = ST_SLEEP;
                else if (rq_halt) next = ST_HALT;
            end
            ST_HALT: begin
                if (rq_rst)        next = ST_RESET;
                else if (rq_pd)    next = ST_SLEEP;
                else if (!rq_halt) next = ST_RUN;
            end
            ST_SLEEP: begin
                if (rq_rst)      next = ST_RESET;
                else if (!rq_pd) next = rq_halt ? ST_HALT : ST_RUN;
            end
            default: next = ST_RESET;
        endcase
    end

    always_comb begin
        cpu_rst_o   = 1'b0;
        cpu_halt_o  = 1'b0;
        cpu_pwrdn_o = 1'b0;
        unique case (state)
            ST_RESET: cpu_rst_o   = 1'b1;
            ST_HALT:  cpu_halt_o  = 1'b1;
            ST_SLEEP: cpu_pwrdn_o = 1'b1;
            default:  ;
        endcase
    end

    assign state_o = state;

    a_r6_reset_entry: assert property (@(posedge clk) disable iff (!rst_n)
        rq_rst |=> cpu_rst_o);

    a_r8_pd_over_halt: assert property (@(posedge clk) disable iff (!rst_n)
        (!rq_rst && rq_pd) |=> (cpu_pwrdn_o && !cpu_halt_o));

    a_r7_halt_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (!rq_rst && !rq_pd && rq_halt) |=> cpu_halt_o);

    a_r6_release: assert property (@(posedge clk) disable iff (!rst_n)
        (!rq_rst && !rq_pd && !rq_halt) |=> (state == ST_RUN));

endmodule

// File: rtl/mbx_host_regs.sv
module mbx_host_regs
    import mbx_pkg::*;
#(
    parameter int DW   = 8,
    parameter int NREG = 8,
    localparam int AW  = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [AW-1:0]     addr,
    input  logic [DW-1:0]     wdata,
    output logic [DW-1:0]     rdata,
    input  logic              h2c_pend_i,
    input  logic              c2h_pend_i,
    input  logic [DW-1:0]     rsp_i,
    input  cpu_state_e        state_i,
    output logic [CTRL_W-1:0] ctrl_o,
    output logic [DW-1:0]     cmd_o,
    output logic              ring_o,
    output logic              ack_o
);

    logic [DW-1:0] view [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        if (g == H_CTRL || g == H_CMD || g >= H_SCR0) begin : g_rw
            localparam logic [DW-1:0] RST = (g == H_CTRL) ? DW'(1 << CTRL_RST) : '0;
            localparam logic [DW-1:0] MSK = (g == H_CTRL) ? DW'((1 << CTRL_W) - 1) : '1;
            logic [DW-1:0] q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    q <= RST;
                else if (we && int'(addr) == g)
                    q <= wdata & MSK;
            end
            assign view[g] = q;
        end else if (g == H_RING) begin : g_ring
            assign view[g] = DW'(h2c_pend_i);
        end else if (g == H_ACK) begin : g_ack
            assign view[g] = DW'(c2h_pend_i);
        end else if (g == H_RSP) begin : g_rsp
            assign view[g] = rsp_i;
        end else begin : g_state
            assign view[g] = DW'(state_i);
        end
    end

    assign rdata  = view[addr];
    assign ctrl_o = view[H_CTRL][CTRL_W-1:0];
    assign cmd_o  = view[H_CMD];
    assign ring_o = we && int'(addr) == H_RING && wdata[0];
    assign ack_o  = we && int'(addr) == H_ACK  && wdata[0];

    a_r9_cmd_store: assert property (@(posedge clk) disable iff (!rst_n)
        (we && int'(addr) == H_CMD) |=> (cmd_o == $past(wdata)));

    a_r10_rsp_untouched: assert property (@(posedge clk) disable iff (!rst_n)
        (we && int'(addr) == H_RSP && $stable(rsp_i)) |-> (view[H_RSP] == rsp_i));

endmodule

// File: rtl/mbx_cpu_regs.sv
module mbx_cpu_regs
    import mbx_pkg::*;
#(
    parameter int DW   = 8,
    parameter int NREG = 16,
    localparam int AW  = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [AW-1:0]     addr,
    input  logic [DW-1:0]     wdata,
    output logic [DW-1:0]     rdata,
    input  logic              h2c_pend_i,
    input  logic              c2h_pend_i,
    input  logic [DW-1:0]     cmd_i,
    input  logic [CTRL_W-1:0] ctrl_i,
    output logic [DW-1:0]     rsp_o,
    output logic              ring_o,
    output logic              ack_o
);

    logic [DW-1:0] view [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        if (g == C_RSP || g >= C_SCR0) begin : g_rw
            logic [DW-1:0] q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    q <= '0;
                else if (we && int'(addr) == g)
                    q <= wdata;
            end
            assign view[g] = q;
        end else if (g == C_STAT) begin : g_stat
            assign view[g] = DW'({ctrl_i[CTRL_PD], ctrl_i[CTRL_HALT]});
        end else if (g == C_ACK) begin : g_ack
            assign view[g] = DW'(h2c_pend_i);
        end else if (g == C_RING) begin : g_ring
            assign view[g] = DW'(c2h_pend_i);
        end else begin : g_cmd
            assign view[g] = cmd_i;
        end
    end

    assign rdata  = view[addr];
    assign rsp_o  = view[C_RSP];
    assign ring_o = we && int'(addr) == C_RING && wdata[0];
    assign ack_o  = we && int'(addr) == C_ACK  && wdata[0];

    a_r10_rsp_store: assert property (@(posedge clk) disable iff (!rst_n)
        (we && int'(addr) == C_RSP) |=> (rsp_o == $past(wdata)));

    a_r7_status_follows: assert property (@(posedge clk) disable iff (!rst_n)
        view[C_STAT][0] == ctrl_i[CTRL_HALT]);

endmodule

// File: rtl/mbx_bank.sv
module mbx_bank
    import mbx_pkg::*;
#(
    parameter int DW     = 8,
    parameter int H_NREG = 8,
    parameter int C_NREG = 16,
    localparam int HAW   = $clog2(H_NREG),
    localparam int CAW   = $clog2(C_NREG)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           h_we,
    input  logic [HAW-1:0] h_addr,
    input  logic [DW-1:0]  h_wdata,
    output logic [DW-1:0]  h_rdata,
    input  logic           c_we,
    input  logic [CAW-1:0] c_addr,
    input  logic [DW-1:0]  c_wdata,
    output logic [DW-1:0]  c_rdata,
    output logic           h2c_irq_o,
    output logic           c2h_irq_o,
    output logic           cpu_rst_o,
    output logic           cpu_halt_o,
    output logic           cpu_pwrdn_o
);

    logic [CTRL_W-1:0] ctrl;
    logic [DW-1:0]     cmd, rsp;
    logic              h_ring, h_ack, c_ring, c_ack;
    logic              h2c_pend, c2h_pend;
    cpu_state_e        state;

    mbx_host_regs #(.DW(DW), .NREG(H_NREG)) u_host (
        .clk(clk), .rst_n(rst_n), .we(h_we), .addr(h_addr),
        .wdata(h_wdata), .rdata(h_rdata),
        .h2c_pend_i(h2c_pend), .c2h_pend_i(c2h_pend),
        .rsp_i(rsp), .state_i(state),
        .ctrl_o(ctrl), .cmd_o(cmd), .ring_o(h_ring), .ack_o(h_ack)
    );

    mbx_cpu_regs #(.DW(DW), .NREG(C_NREG)) u_cpu (
        .clk(clk), .rst_n(rst_n), .we(c_we), .addr(c_addr),
        .wdata(c_wdata), .rdata(c_rdata),
        .h2c_pend_i(h2c_pend), .c2h_pend_i(c2h_pend),
        .cmd_i(cmd), .ctrl_i(ctrl),
        .rsp_o(rsp), .ring_o(c_ring), .ack_o(c_ack)
    );

    mbx_irq_link u_h2c (
        .clk(clk), .rst_n(rst_n), .set_i(h_ring), .clr_i(c_ack), .pend_o(h2c_pend)
    );

    mbx_irq_link u_c2h (
        .clk(clk), .rst_n(rst_n), .set_i(c_ring), .clr_i(h_ack), .pend_o(c2h_pend)
    );

    mbx_ctrl_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .ctrl_i(ctrl), .state_o(state),
        .cpu_rst_o(cpu_rst_o), .cpu_halt_o(cpu_halt_o), .cpu_pwrdn_o(cpu_pwrdn_o)
    );

    assign h2c_irq_o = h2c_pend;
    assign c2h_irq_o = c2h_pend;

    a_r1_irq_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(h2c_irq_o) |-> $past(h_we));

endmodule

// File: tb/mbx_bank_tb.sv
module mbx_bank_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       h_we = 1'b0;
    logic [2:0] h_addr = '0;
    logic [7:0] h_wdata = '0;
    logic [7:0] h_rdata;
    logic       c_we = 1'b0;
    logic [3:0] c_addr = '0;
    logic [7:0] c_wdata = '0;
    logic [7:0] c_rdata;
    logic       h2c_irq_o, c2h_irq_o, cpu_rst_o, cpu_halt_o, cpu_pwrdn_o;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    mbx_bank u_dut (
        .clk(clk), .rst_n(rst_n),
        .h_we(h_we), .h_addr(h_addr), .h_wdata(h_wdata), .h_rdata(h_rdata),
        .c_we(c_we), .c_addr(c_addr), .c_wdata(c_wdata), .c_rdata(c_rdata),
        .h2c_irq_o(h2c_irq_o), .c2h_irq_o(c2h_irq_o),
        .cpu_rst_o(cpu_rst_o), .cpu_halt_o(cpu_halt_o), .cpu_pwrdn_o(cpu_pwrdn_o)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000 && !done) begin
            done = 1'b1;
            failures++;
            $display("FAIL watchdog act=%0d exp=<20000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // {wside, waddr, wdata, rside, raddr, exp}; side 0 = host, 1 = cpu
    localparam int NV = 8;
    localparam logic [25:0] VEC [NV] = '{
        {1'b0, 4'd3, 8'hA5, 1'b1, 4'd3, 8'hA5},  // R9 command seen by cpu
        {1'b1, 4'd3, 8'h00, 1'b1, 4'd3, 8'hA5},  // R9 cpu write ignored
        {1'b1, 4'd4, 8'h3C, 1'b0, 4'd4, 8'h3C},  // R10 response seen by host
        {1'b0, 4'd4, 8'hFF, 1'b1, 4'd4, 8'h3C},  // R10 host write ignored
        {1'b0, 4'd6, 8'h11, 1'b0, 4'd6, 8'h11},  // R11 host scratch
        {1'b1, 4'd15, 8'h77, 1'b1, 4'd15, 8'h77},// R11 cpu scratch top
        {1'b0, 4'd7, 8'h99, 1'b1, 4'd7, 8'h00},  // R11 not visible on cpu side
        {1'b1, 4'd0, 8'hFF, 1'b1, 4'd0, 8'h00}   // R7 cpu status not writable
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic hwr(input logic [2:0] a, input logic [7:0] d);
        h_we = 1'b1; h_addr = a; h_wdata = d;
        @(negedge clk);
        h_we = 1'b0;
    endtask

    task automatic cwr(input logic [3:0] a, input logic [7:0] d);
        c_we = 1'b1; c_addr = a; c_wdata = d;
        @(negedge clk);
        c_we = 1'b0;
    endtask

    task automatic both(input logic [2:0] ha, input logic [3:0] ca);
        h_we = 1'b1; h_addr = ha; h_wdata = 8'h01;
        c_we = 1'b1; c_addr = ca; c_wdata = 8'h01;
        @(negedge clk);
        h_we = 1'b0; c_we = 1'b0;
    endtask

    task automatic hrd(input logic [2:0] a, output logic [7:0] d);
        h_addr = a; #1; d = h_rdata;
    endtask

    task automatic crd(input logic [3:0] a, output logic [7:0] d);
        c_addr = a; #1; d = c_rdata;
    endtask

    initial begin
        logic [7:0] rd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        hrd(3'd0, rd);  check("R1 ctrl", rd, 8'h01);
        check("R1 h2c", {7'd0, h2c_irq_o}, 8'h00);
        check("R1 c2h", {7'd0, c2h_irq_o}, 8'h00);
        check("R1 cpu_rst", {7'd0, cpu_rst_o}, 8'h01);
        hrd(3'd5, rd);  check("R12 reset code", rd, 8'h00);

        // vector table
        for (int i = 0; i < NV; i++) begin
            logic [25:0] v;
            string tag;
            v = VEC[i];
            if (v[25]) cwr(v[24:21], v[20:13]);
            else       hwr(v[23:21], v[20:13]);
            if (v[12]) crd(v[11:8], rd);
            else       hrd(v[10:8], rd);
            tag = $sformatf("R9-R11 vec%0d", i);
            check(tag, rd, v[7:0]);
        end

        // R6 release from reset: state follows one cycle late
        hwr(3'd0, 8'h00);
        check("R6 still reset", {7'd0, cpu_rst_o}, 8'h01);
        @(negedge clk);
        check("R6 released", {7'd0, cpu_rst_o}, 8'h00);
        hrd(3'd5, rd);  check("R12 run code", rd, 8'h01);

        // R7 halt
        hwr(3'd0, 8'h02);
        crd(4'd0, rd);  check("R7 status halt", rd, 8'h01);
        @(negedge clk);
        check("R7 halt out", {7'd0, cpu_halt_o}, 8'h01);
        hrd(3'd5, rd);  check("R12 halt code", rd, 8'h02);

        // R8 power-down outranks halt
        hwr(3'd0, 8'h06);
        crd(4'd0, rd);  check("R8 status", rd, 8'h03);
        @(negedge clk);
        check("R8 pwrdn out", {6'd0, cpu_pwrdn_o, cpu_halt_o}, 8'h02);
        hrd(3'd5, rd);  check("R12 sleep code", rd, 8'h03);

        // R6 reset outranks both
        hwr(3'd0, 8'h07);
        @(negedge clk);
        check("R6 reset wins", {5'd0, cpu_rst_o, cpu_pwrdn_o, cpu_halt_o}, 8'h04);
        hwr(3'd0, 8'h00);
        @(negedge clk);
        check("R6 run again", {5'd0, cpu_rst_o, cpu_pwrdn_o, cpu_halt_o}, 8'h00);

        // R2 / R3 host-to-cpu doorbell
        hwr(3'd1, 8'h01);
        check("R2 h2c irq", {7'd0, h2c_irq_o}, 8'h01);
        crd(4'd1, rd);  check("R2 cpu sees", rd, 8'h01);
        cwr(4'd1, 8'h00);
        check("R3 zero ignored", {7'd0, h2c_irq_o}, 8'h01);
        cwr(4'd1, 8'h01);
        check("R3 cleared", {7'd0, h2c_irq_o}, 8'h00);

        // R4 cpu-to-host doorbell
        cwr(4'd2, 8'h01);
        check("R4 c2h irq", {7'd0, c2h_irq_o}, 8'h01);
        hrd(3'd2, rd);  check("R4 host sees", rd, 8'h01);
        hwr(3'd2, 8'h01);
        check("R4 cleared", {7'd0, c2h_irq_o}, 8'h00);

        // R5 set wins over simultaneous clear
        both(3'd1, 4'd1);
        check("R5 h2c from idle", {7'd0, h2c_irq_o}, 8'h01);
        both(3'd1, 4'd1);
        check("R5 h2c while pending", {7'd0, h2c_irq_o}, 8'h01);
        both(3'd2, 4'd2);
        check("R5 c2h", {7'd0, c2h_irq_o}, 8'h01);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule